// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Concentrator

This block gathers 64 interrupt request lines into one cascade interrupt toward an upstream controller. Every source owns a pair of 32-bit configuration words that hold a two-bit enable, a sense code, a four-bit target field and an eight-bit priority. On every clock the block works out which enabled sources are active and selects the one with the largest priority byte. The number of that source is placed in a status register. The cascade line is raised while a real source is reported and both the global detection switch and the output switch are on.

Most sources act as active-high level inputs. A small window of sources, 47 through 50 by default, can also be set to active-low level or to rising or falling edge. An edge-configured source keeps its own latch, which stays set until software writes a clear command that names the source. Software reads the status register inside the cascade handler. A reading of 63 means nothing is pending.

Top module: `extint_hub`

## Requirements
- R1: After reset the status register (offset 0x144) reads 0x3F000000, the cascade output is low, and every configuration word and both enable registers read zero.
- R2: Source n has word A at 0x200+8n and word B at 0x204+8n. Word A reads back only bits 29:28 (enable), 25:24 (sense) and 7:4 (target). Word B reads back only bits 7:0 (priority). All other bits read zero.
- R3: A source takes part in selection only when both enable bits 29:28 of its word A are 1. Either bit alone leaves the source masked.
- R4: A source outside the edge window behaves as an active-high level input, whatever sense code it holds.
- R5: A source inside the edge window with sense code 0 is pending while its input is low. With sense code 1 it is pending while its input is high.
- R6: A source inside the edge window with sense code 3 latches a 0-to-1 input change, and with code 2 latches a 1-to-0 change. It stays pending after the input returns, and the latch only sets after such a change.
- R7: A write to 0x0C0 with bit 8 set clears the latch of the edge-window source whose number's low four bits equal data bits 3:0. With bit 8 clear, or with a nibble naming another source, nothing changes. A qualifying edge in the same cycle as a clear leaves the latch set.
- R8: Among pending sources the largest priority byte wins, and a tie goes to the lower source number.
- R9: Status bits 31:24 show the winner one clock after the pending set changes, and show 63 when nothing is pending.
- R10: Bit 0 of the detection register (0x004) gates detection. While it is 0 no source is pending and no edge is latched. The bit reads back.
- R11: Bit 0 of the output register (0x444) reads back. The cascade output is high exactly when the status is not 63 and both enable bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_in | input | 64 | Interrupt request lines, synchronous to clk |
| cascade_irq | output | 1 | Interrupt toward the upstream controller |

## Verification
The selection logic is tried in several ways. One case has a single active source. Another has three sources where two share a priority byte, which separates the tie-break from plain comparison. A further case raises the priority of the lowest source so that the order flips. The sense logic is checked level-high and level-low on an edge-window source and with non-default codes on an ordinary source. This tells correct treatment apart from decoding of codes that ought to be ignored. Edge latches are checked for both polarities, with clear commands that lack the qualifying bit, that name a neighbour, or that collide with a fresh edge, so that clear decoding, latch hold and set-over-clear precedence are each observed at the status register.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam logic [11:0] ADR_DETECT   = 12'h004;
  localparam logic [11:0] ADR_EDGE_CLR = 12'h0C0;
  localparam logic [11:0] ADR_STATUS   = 12'h144;
  localparam logic [11:0] ADR_CFG_BASE = 12'h200;
  localparam logic [11:0] ADR_OUT_EN   = 12'h444;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'd0,
    SNS_HIGH = 2'd1,
    SNS_FALL = 2'd2,
    SNS_RISE = 2'd3
  } sense_e;

  typedef struct packed {
    logic       vld;
    logic [7:0] pri;
    logic [7:0] id;
  } cand_t;

  // higher byte wins; on a tie the lower-numbered side (lo) is kept
  function automatic cand_t pick_cand(cand_t lo, cand_t hi);
    if (hi.vld && (!lo.vld || (hi.pri > lo.pri))) return hi;
    return lo;
  endfunction

  function automatic bit edge_capable(int n, int lo, int hi);
    return (n >= lo) && (n <= hi);
  endfunction

  function automatic logic clr_match(logic [31:0] wd, int n);
    return wd[8] && (wd[3:0] == 4'(n));
  endfunction

  function automatic logic [31:0] cfg_a_word(logic [1:0] en, logic [1:0] sns, logic [3:0] tgt);
    return {2'b00, en, 2'b00, sns, 16'h0000, tgt, 4'h0};
  endfunction

  function automatic logic [31:0] status_word(logic [7:0] id);
    return {id, 24'h000000};
  endfunction

endpackage

// File: rtl/extint_src_cell.sv
module extint_src_cell
  import extint_pkg::*;
#(
  parameter bit EDGE_OK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       det_en,
  input  logic       src_en,
  input  logic [1:0] sense,
  input  logic       pin,
  input  logic       clr,
  output logic       pend,
  output logic       edge_evt,
  output logic       edge_lat
);

  generate
    if (EDGE_OK) begin : g_edge
      logic prev_q;
      logic lat_q;
      logic rise_w;
      logic fall_w;
      logic active_w;

      assign rise_w   = pin & ~prev_q;
      assign fall_w   = ~pin & prev_q;
      assign edge_evt = det_en & (((sense == SNS_RISE) & rise_w) |
                                  ((sense == SNS_FALL) & fall_w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          lat_q  <= 1'b0;
        end else begin
          prev_q <= pin;
          lat_q  <= edge_evt | (lat_q & ~clr);
        end
      end

      always_comb begin
        case (sense)
          SNS_LOW:  active_w = ~pin;
          SNS_HIGH: active_w = pin;
          default:  active_w = lat_q;
        endcase
      end

      assign edge_lat = lat_q;
      assign pend     = det_en & src_en & active_w;
    end else begin : g_level
      logic unused_lvl;
      assign unused_lvl = ^{clk, rst_n, sense, clr};
      assign edge_evt   = 1'b0;
      assign edge_lat   = 1'b0;
      assign pend       = det_en & src_en & pin;
    end
  endgenerate

endmodule

// File: rtl/extint_cfg_bank.sv
module extint_cfg_bank
  import extint_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int AW      = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [31:0]               wdata,
  output logic [NUM_SRC-1:0]        src_en,
  output logic [NUM_SRC-1:0][1:0]   src_sense,
  output logic [NUM_SRC-1:0][7:0]   src_prio,
  output logic                      hit,
  output logic [31:0]               rdata
);

  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int SPAN  = 8 * NUM_SRC;

  logic [NUM_SRC-1:0][1:0] en_q;
  logic [NUM_SRC-1:0][1:0] sns_q;
  logic [NUM_SRC-1:0][3:0] tgt_q;
  logic [NUM_SRC-1:0][7:0] pri_q;

  logic [AW-1:0]    offs;
  logic [IDX_W-1:0] idx;
  logic             is_b;
  logic             unused_bits;

  assign offs        = addr - ADR_CFG_BASE[AW-1:0];
  assign hit         = (addr >= ADR_CFG_BASE[AW-1:0]) && (32'(offs) < 32'(SPAN));
  assign idx         = offs[IDX_W+2:3];
  assign is_b        = offs[2];
  assign unused_bits = ^{wdata[31:30], wdata[27:26], wdata[23:8], wdata[3:0], offs[1:0]};

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q[i]  <= 2'b00;
          sns_q[i] <= 2'b00;
          tgt_q[i] <= 4'h0;
          pri_q[i] <= 8'h00;
        end else if (we && hit && (idx == IDX_W'(i))) begin
          if (is_b) begin
            pri_q[i] <= wdata[7:0];
          end else begin
            en_q[i]  <= wdata[29:28];
            sns_q[i] <= wdata[25:24];
            tgt_q[i] <= wdata[7:4];
          end
        end
      end
      assign src_en[i]    = &en_q[i];
      assign src_sense[i] = sns_q[i];
      assign src_prio[i]  = pri_q[i];
    end
  endgenerate

  always_comb begin
    rdata = 32'h0;
    if (hit) begin
      if (is_b) rdata = {24'h000000, pri_q[idx]};
      else      rdata = cfg_a_word(en_q[idx], sns_q[idx], tgt_q[idx]);
    end
  end

endmodule

// File: rtl/extint_prio_tree.sv
module extint_prio_tree
  import extint_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0]           pend,
  input  logic [NUM_SRC-1:0][7:0]      prio,
  output logic                         win_vld,
  output logic [$clog2(NUM_SRC)-1:0]   win_id
);

  localparam int ID_W  = $clog2(NUM_SRC);
  localparam int NODES = 2 * NUM_SRC - 1;

  cand_t node [NODES];
  logic  unused_id;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
      assign node[NUM_SRC-1+i] = '{vld: pend[i], pri: prio[i], id: 8'(i)};
    end
    for (genvar k = 0; k < NUM_SRC - 1; k++) begin : g_node
      assign node[k] = pick_cand(node[2*k+1], node[2*k+2]);
    end
    if (ID_W < 8) begin : g_wide
      assign unused_id = ^node[0].id[7:ID_W];
    end else begin : g_full
      assign unused_id = 1'b0;
    end
  endgenerate

  assign win_vld = node[0].vld;
  assign win_id  = node[0].id[ID_W-1:0];

endmodule

// File: rtl/extint_hub.sv
module extint_hub
  import extint_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int EDGE_LO = 47,
  parameter int EDGE_HI = 50,
  parameter int AW      = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               cascade_irq
);

  localparam int             ID_W    = $clog2(NUM_SRC);
  localparam logic [ID_W-1:0] IDLE_ID = ID_W'(NUM_SRC - 1);

  logic                     det_en_q;
  logic                     out_en_q;
  logic [ID_W-1:0]          cur_id_q;

  logic [NUM_SRC-1:0]       src_en;
  logic [NUM_SRC-1:0][1:0]  src_sense;
  logic [NUM_SRC-1:0][7:0]  src_prio;
  logic                     cfg_hit;
  logic [31:0]              cfg_rdata;

  logic [NUM_SRC-1:0]       pend_vec;
  logic [NUM_SRC-1:0]       edge_evt;
  logic [NUM_SRC-1:0]       edge_lat;
  logic [NUM_SRC-1:0]       edge_clr;

  logic                     win_vld;
  logic [ID_W-1:0]          win_id;

  logic                     sel_detect;
  logic                     sel_out_en;
  logic                     sel_status;
  logic                     sel_clr;

  assign sel_detect = bus_addr[AW-1:2] == ADR_DETECT[AW-1:2];
  assign sel_out_en = bus_addr[AW-1:2] == ADR_OUT_EN[AW-1:2];
  assign sel_status = bus_addr[AW-1:2] == ADR_STATUS[AW-1:2];
  assign sel_clr    = bus_addr[AW-1:2] == ADR_EDGE_CLR[AW-1:2];

  extint_cfg_bank #(.NUM_SRC(NUM_SRC), .AW(AW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (bus_we),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .src_en    (src_en),
    .src_sense (src_sense),
    .src_prio  (src_prio),
    .hit       (cfg_hit),
    .rdata     (cfg_rdata)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam bit EOK = edge_capable(i, EDGE_LO, EDGE_HI);
      assign edge_clr[i] = EOK && bus_we && sel_clr && clr_match(bus_wdata, i);
      extint_src_cell #(.EDGE_OK(EOK)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .det_en   (det_en_q),
        .src_en   (src_en[i]),
        .sense    (src_sense[i]),
        .pin      (src_in[i]),
        .clr      (edge_clr[i]),
        .pend     (pend_vec[i]),
        .edge_evt (edge_evt[i]),
        .edge_lat (edge_lat[i])
      );
    end
  endgenerate

  extint_prio_tree #(.NUM_SRC(NUM_SRC)) u_tree (
    .pend    (pend_vec),
    .prio    (src_prio),
    .win_vld (win_vld),
    .win_id  (win_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_en_q <= 1'b0;
      out_en_q <= 1'b0;
      cur_id_q <= IDLE_ID;
    end else begin
      if (bus_we && sel_detect) det_en_q <= bus_wdata[0];
      if (bus_we && sel_out_en) out_en_q <= bus_wdata[0];
      cur_id_q <= win_vld ? win_id : IDLE_ID;
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (cfg_hit)         bus_rdata = cfg_rdata;
    else if (sel_detect) bus_rdata = {31'h0, det_en_q};
    else if (sel_out_en) bus_rdata = {31'h0, out_en_q};
    else if (sel_status) bus_rdata = status_word(8'(cur_id_q));
  end

  assign cascade_irq = (cur_id_q != IDLE_ID) & det_en_q & out_en_q;

endmodule

// File: rtl/extint_hub_chk.sv
module extint_hub_chk #(
  parameter int NUM_SRC = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       det_en,
  input logic                       out_en,
  input logic                       cascade,
  input logic [$clog2(NUM_SRC)-1:0] cur_id,
  input logic [NUM_SRC-1:0]         pend_vec,
  input logic [NUM_SRC-1:0]         edge_evt,
  input logic [NUM_SRC-1:0]         edge_lat,
  input logic [NUM_SRC-1:0]         edge_clr
);

  localparam int ID_W = $clog2(NUM_SRC);
  localparam logic [ID_W-1:0] IDLE_ID = ID_W'(NUM_SRC - 1);

  logic [NUM_SRC-1:0] pend_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_prev <= '0;
    else        pend_prev <= pend_vec;
  end

  AST_IDLE_NO_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_id == IDLE_ID) |-> !cascade); // R11

  AST_CASCADE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cascade |-> (det_en && out_en)); // R11

  AST_DETECT_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> (cur_id == IDLE_ID)); // R10

  AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_clr & ~edge_evt)) |=> ((edge_lat & $past(edge_clr & ~edge_evt)) == '0)); // R7

  AST_LATCH_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_lat & ~$past(edge_lat) & ~$past(edge_evt)) == '0)); // R6

  AST_REPORTED_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_id != IDLE_ID) |-> pend_prev[cur_id]); // R9

endmodule

bind extint_hub extint_hub_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .det_en   (det_en_q),
  .out_en   (out_en_q),
  .cascade  (cascade_irq),
  .cur_id   (cur_id_q),
  .pend_vec (pend_vec),
  .edge_evt (edge_evt),
  .edge_lat (edge_lat),
  .edge_clr (edge_clr)
);

// File: tb/extint_hub_tb.sv
module extint_hub_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] src_in;
  logic        cascade_irq;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [11:0] A_DET = 12'h004;
  localparam logic [11:0] A_CLR = 12'h0C0;
  localparam logic [11:0] A_STS = 12'h144;
  localparam logic [11:0] A_OEN = 12'h444;
  localparam logic [31:0] IDLE  = 32'h3F00_0000;

  always #4 clk = ~clk;

  extint_hub u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .cascade_irq(cascade_irq)
  );

  function automatic logic [11:0] cfg_a(int n); return 12'(12'h200 + 8 * n); endfunction
  function automatic logic [11:0] cfg_b(int n); return 12'(12'h204 + 8 * n); endfunction
  function automatic logic [31:0] sts(int n);   return {8'(n), 24'h0}; endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_sts(string tag, int n);
    logic [31:0] d;
    rd(A_STS, d);
    chk(tag, d, sts(n));
  endtask

  task automatic pin(int n, logic v);
    @(negedge clk);
    src_in[n] = v;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STS, d);            chk("R1 status idle", d, IDLE);
    chk("R1 cascade low", {31'h0, cascade_irq}, 32'h0);
    rd(cfg_a(5), d);         chk("R1 cfg A zero", d, 32'h0);
    rd(cfg_b(63), d);        chk("R1 cfg B zero", d, 32'h0);
    rd(A_DET, d);            chk("R1 detect zero", d, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(cfg_a(10), 32'hFFFF_FFFF);
    rd(cfg_a(10), d);        chk("R2 word A fields", d, 32'h3300_00F0);
    wr(cfg_b(10), 32'hFFFF_FFFF);
    rd(cfg_b(10), d);        chk("R2 word B field", d, 32'h0000_00FF);
    rd(cfg_a(11), d);        chk("R2 neighbour untouched", d, 32'h0);
    wr(cfg_a(10), 32'h0);
    wr(cfg_b(10), 32'h0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(A_DET, 32'h1);
    wr(A_OEN, 32'h1);
    rd(A_DET, d);            chk("R10 detect readback", d, 32'h1);
    rd(A_OEN, d);            chk("R11 output readback", d, 32'h1);
  endtask

  task automatic t_level();
    wr(cfg_a(3), 32'h3100_0000);
    wr(cfg_b(3), 32'h5);
    @(negedge clk);
    src_in[3] = 1'b1;
    #1 chk_sts("R9 status before edge", 63);
    @(posedge clk); @(negedge clk);
    chk_sts("R9 status one clock later", 3);
    chk("R11 cascade high", {31'h0, cascade_irq}, 32'h1);
    src_in[3] = 1'b0;
    @(posedge clk); @(negedge clk);
    chk_sts("R9 back to idle", 63);
    chk("R11 cascade low when idle", {31'h0, cascade_irq}, 32'h0);
  endtask

  task automatic t_mask();
    pin(3, 1'b1);
    wr(cfg_a(3), 32'h1100_0000); settle();
    chk_sts("R3 bit28 alone masks", 63);
    wr(cfg_a(3), 32'h2100_0000); settle();
    chk_sts("R3 bit29 alone masks", 63);
    wr(cfg_a(3), 32'h3100_0000); settle();
    chk_sts("R3 both bits enable", 3);
  endtask

  task automatic t_plain_sense();
    wr(cfg_a(3), 32'h3000_0000); settle();
    chk_sts("R4 low code still high-active", 3);
    pin(3, 1'b0); settle();
    chk_sts("R4 low input not pending", 63);
    wr(cfg_a(3), 32'h3300_0000);
    pin(3, 1'b1); pin(3, 1'b0); settle();
    chk_sts("R4 rise code no latch", 63);
    wr(cfg_a(3), 32'h0);
  endtask

  task automatic t_level_low();
    wr(cfg_b(48), 32'h1);
    wr(cfg_a(48), 32'h3000_0000); settle();
    chk_sts("R5 low-active pending on low", 48);
    pin(48, 1'b1); settle();
    chk_sts("R5 low-active idle on high", 63);
    wr(cfg_a(48), 32'h3100_0000); settle();
    chk_sts("R5 high-active pending on high", 48);
    pin(48, 1'b0);
    wr(cfg_a(48), 32'h0); settle();
  endtask

  task automatic t_edge();
    wr(cfg_b(49), 32'h2);
    wr(cfg_a(49), 32'h3300_0000);
    pin(49, 1'b1); settle();
    chk_sts("R6 rising edge latched", 49);
    pin(49, 1'b0); settle();
    chk_sts("R6 latch holds after input drops", 49);
    wr(A_CLR, 32'h0000_0001); settle();
    chk_sts("R7 clear without bit8 ignored", 49);
    wr(A_CLR, 32'h0000_0101); settle();
    chk_sts("R7 clear releases source", 63);
    wr(cfg_a(47), 32'h3200_0000);
    pin(47, 1'b1); settle();
    chk_sts("R6 falling code ignores rise", 63);
    pin(47, 1'b0); settle();
    chk_sts("R6 falling edge latched", 47);
    wr(A_CLR, 32'h0000_010F); settle();
    chk_sts("R7 nibble F clears source 47", 63);
  endtask

  task automatic t_clear_race();
    wr(cfg_a(50), 32'h3300_0000);
    @(negedge clk);
    src_in[50] = 1'b1;
    bus_we = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h0000_0102;
    @(negedge clk);
    bus_we = 1'b0;
    settle();
    chk_sts("R7 new edge beats clear", 50);
    wr(A_CLR, 32'h0000_0101); settle();
    chk_sts("R7 other nibble keeps latch", 50);
    wr(A_CLR, 32'h0000_0102); settle();
    chk_sts("R7 own nibble clears", 63);
    pin(50, 1'b0);
    wr(cfg_a(47), 32'h0);
    wr(cfg_a(50), 32'h0);
    wr(cfg_a(49), 32'h0);
  endtask

  task automatic t_prio();
    wr(cfg_a(10), 32'h3100_0000); wr(cfg_b(10), 32'd7);
    wr(cfg_a(20), 32'h3100_0000); wr(cfg_b(20), 32'd9);
    wr(cfg_a(30), 32'h3100_0000); wr(cfg_b(30), 32'd9);
    @(negedge clk);
    src_in[10] = 1'b1; src_in[20] = 1'b1; src_in[30] = 1'b1;
    settle();
    chk_sts("R8 tie goes to lower number", 20);
    pin(20, 1'b0); settle();
    chk_sts("R8 next highest wins", 30);
    wr(cfg_b(10), 32'd200); settle();
    chk_sts("R8 larger byte wins", 10);
  endtask

  task automatic t_out_en();
    wr(A_OEN, 32'h0); settle();
    chk_sts("R11 status kept with output off", 10);
    chk("R11 cascade off with output off", {31'h0, cascade_irq}, 32'h0);
    wr(A_OEN, 32'h1); settle();
    chk("R11 cascade back on", {31'h0, cascade_irq}, 32'h1);
  endtask

  task automatic t_detect();
    wr(A_DET, 32'h0); settle();
    chk_sts("R10 detect off idle", 63);
    chk("R10 cascade off", {31'h0, cascade_irq}, 32'h0);
    @(negedge clk);
    src_in[10] = 1'b0; src_in[30] = 1'b0;
    wr(cfg_a(49), 32'h3300_0000);
    pin(49, 1'b1); settle();
    wr(A_DET, 32'h1); settle();
    chk_sts("R10 edge not captured while off", 63);
    pin(49, 1'b0); pin(49, 1'b1); settle();
    chk_sts("R10 edge captured once on", 49);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 12'h0; bus_wdata = 32'h0; src_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_enables();
    t_level();
    t_mask();
    t_plain_sense();
    t_level_low();
    t_edge();
    t_clear_race();
    t_prio();
    t_out_en();
    t_detect();
    summary();
  end

endmodule